// File: doc/BRIEF.md
# Cyclic Redundant-Digit Conversion Sequencer

This block is the digital controller for a cyclic analog-to-digital converter that resolves one redundant signed digit per iteration. The analog residue stage starts from the sampled input. In each iteration the sequencer first strobes two coarse comparators and reads their flags on the next clock. One flag reports that the residue is above a positive threshold and the other that it is below the matching negative threshold. From the flags the sequencer picks a digit of +1, 0 or -1. It also tells the switched-capacitor stage how to form the next residue: doubled minus the reference, doubled plus the reference, or just doubled.

The sequencer folds the digits, most significant first, into a signed accumulator as they arrive. When the last digit is in, it presents an n-bit two's-complement word together with a one-clock completion pulse. The word length is taken at the start of each conversion and is clamped to the range from two bits to a parameterised maximum. Because the comparators may be coarse, both flags may be seen high at once. The sequencer treats that case as a zero digit and records it in a sticky error flag.

Top module: `rsd_sequencer`

## Requirements
- R1: After reset, busy, done, err, cmpStrobe and resUpdate are 0, resSel is 2'b00 and result is all zeros.
- R2: A start pulse seen in idle makes busy high from the next cycle. Each iteration is a strobe cycle (cmpStrobe=1) followed at once by a decision cycle (resUpdate=1) in which the flags are sampled. The first strobe cycle is the cycle right after the start edge.
- R3: In a decision cycle resSel is 2'b10 (subtract reference, digit +1) when only cmpAbove is high, 2'b01 (add reference, digit -1) when only cmpBelow is high, and 2'b00 (double only, digit 0) otherwise. Outside decision cycles resSel is 2'b00 and resUpdate is 0.
- R4: A conversion has exactly n decision cycles. n is numBits clamped to the range 2..MAX_BITS (default 15) and is captured at the accepted start. Later changes to numBits do not affect a running conversion.
- R5: The digits d0 (first) through d(n-1) give A = sum of d_i * 2^(n-1-i). The result is A as a signed value sign-extended to MAX_BITS bits. It appears together with a one-cycle done pulse 2n cycles after the start edge, and busy is 0 in that cycle.
- R6: When A exceeds 2^(n-1)-1, the result is 2^(n-1)-1. When A is below -2^(n-1), the result is -2^(n-1).
- R7: If both flags are high in a decision cycle, that digit is 0 and err rises in the next cycle. err then stays high until the next accepted start, which clears it.
- R8: A start asserted while busy is ignored: the running conversion keeps its count, timing and result.
- R9: The result holds its value from one done pulse to the next, including during a later conversion.
- R10: Comparator flags outside decision cycles have no effect on the digits, err or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion when idle |
| numBits | input | $clog2(MAX_BITS+1) | Requested word length |
| cmpAbove | input | 1 | Comparator flag: residue above +threshold |
| cmpBelow | input | 1 | Comparator flag: residue below -threshold |
| cmpStrobe | output | 1 | Comparator evaluate strobe |
| resUpdate | output | 1 | Residue stage applies resSel this cycle |
| resSel | output | 2 | Residue operation code |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | MAX_BITS | Signed result, sign-extended |
| err | output | 1 | Sticky both-flags-high error |

## Verification
Taking the start edge as cycle 0, iteration i has its strobe cycle at 2i+1 and its decision cycle at 2i+2. The done pulse and the new result are due at cycle 2n+1, counting the cycle that follows each edge. The bench keeps a behavioural model of the residue with real arithmetic and a digit accumulator. It drives inputs on falling edges and compares every output in each of these cycles, so an early or late output at any point fails a named check. resSel is checked shortly after the flags settle within the decision cycle, and err and the held result are checked one cycle after the sampling edge.

// File: rtl/rsd_seq_pkg.sv
package rsd_seq_pkg;
  typedef enum logic [1:0] {
    SEL_DOUBLE  = 2'b00,
    SEL_ADD_REF = 2'b01,
    SEL_SUB_REF = 2'b10
  } resSel_e;

  // strobes from the sequencer control to the digit datapath
  typedef struct packed {
    logic clearAcc;
    logic decide;
    logic lastDigit;
  } seqCtrl_t;

  localparam int MIN_BITS = 2;
endpackage

// File: rtl/rsd_seq_ctrl.sv
module rsd_seq_ctrl
  import rsd_seq_pkg::*;
#(
  parameter int MAX_BITS = 15,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] numBits,
  output seqCtrl_t         ctrl,
  output logic [CNT_W-1:0] nEff,
  output logic             busy,
  output logic             cmpStrobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_STROBE, ST_DECIDE} state_e;

  localparam logic [CNT_W-1:0] N_MIN = CNT_W'(MIN_BITS);
  localparam logic [CNT_W-1:0] N_MAX = CNT_W'(MAX_BITS);

  state_e           state;
  logic [CNT_W-1:0] iter;
  logic [CNT_W-1:0] nClamped;
  logic             atLast;

  always_comb begin
    if (numBits < N_MIN)      nClamped = N_MIN;
    else if (numBits > N_MAX) nClamped = N_MAX;
    else                      nClamped = numBits;
  end

  assign atLast = (iter == nEff - CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      iter  <= '0;
      nEff  <= N_MAX;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          nEff  <= nClamped;
          iter  <= '0;
          state <= ST_STROBE;
        end
        ST_STROBE: state <= ST_DECIDE;
        ST_DECIDE: begin
          if (atLast) state <= ST_IDLE;
          else begin
            iter  <= iter + CNT_W'(1);
            state <= ST_STROBE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy           = (state != ST_IDLE);
  assign cmpStrobe      = (state == ST_STROBE);
  assign ctrl.clearAcc  = (state == ST_IDLE) && start;
  assign ctrl.decide    = (state == ST_DECIDE);
  assign ctrl.lastDigit = (state == ST_DECIDE) && atLast;
endmodule

// File: rtl/rsd_seq_datapath.sv
module rsd_seq_datapath
  import rsd_seq_pkg::*;
#(
  parameter int MAX_BITS = 15,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtrl_t            ctrl,
  input  logic [CNT_W-1:0]    nEff,
  input  logic                cmpAbove,
  input  logic                cmpBelow,
  output logic [1:0]          resSel,
  output logic                resUpdate,
  output logic [MAX_BITS-1:0] result,
  output logic                done,
  output logic                err
);
  localparam int ACC_W = MAX_BITS + 2;

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] accNext;
  logic signed [ACC_W-1:0] digitVal;
  logic signed [ACC_W-1:0] posLim;
  logic signed [ACC_W-1:0] negLim;
  logic signed [ACC_W-1:0] satVal;
  logic aboveOnly, belowOnly, conflict;

  assign aboveOnly = cmpAbove && !cmpBelow;
  assign belowOnly = cmpBelow && !cmpAbove;
  assign conflict  = cmpAbove && cmpBelow;

  always_comb begin
    resSel = SEL_DOUBLE;
    if (ctrl.decide) begin
      if (aboveOnly)      resSel = SEL_SUB_REF;
      else if (belowOnly) resSel = SEL_ADD_REF;
    end
  end
  assign resUpdate = ctrl.decide;

  always_comb begin
    if (aboveOnly)      digitVal = ACC_W'(1);
    else if (belowOnly) digitVal = -ACC_W'(1);
    else                digitVal = '0;
  end

  assign accNext = (acc <<< 1) + digitVal;
  assign posLim  = (ACC_W'(1) <<< (nEff - CNT_W'(1))) - ACC_W'(1);
  assign negLim  = -posLim - ACC_W'(1);

  always_comb begin
    if (accNext > posLim)      satVal = posLim;
    else if (accNext < negLim) satVal = negLim;
    else                       satVal = accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= ctrl.decide && ctrl.lastDigit;
      if (ctrl.clearAcc) begin
        acc <= '0;
        err <= 1'b0;
      end else if (ctrl.decide) begin
        acc <= accNext;
        if (conflict) err <= 1'b1;
        if (ctrl.lastDigit) result <= satVal[MAX_BITS-1:0];
      end
    end
  end
endmodule

// File: rtl/rsd_sequencer.sv
module rsd_sequencer
  import rsd_seq_pkg::*;
#(
  parameter int MAX_BITS = 15
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic [$clog2(MAX_BITS+1)-1:0]  numBits,
  input  logic                           cmpAbove,
  input  logic                           cmpBelow,
  output logic                           cmpStrobe,
  output logic                           resUpdate,
  output logic [1:0]                     resSel,
  output logic                           busy,
  output logic                           done,
  output logic [MAX_BITS-1:0]            result,
  output logic                           err
);
  localparam int CNT_W = $clog2(MAX_BITS + 1);

  seqCtrl_t         ctrl;
  logic [CNT_W-1:0] nEff;

  rsd_seq_ctrl #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .numBits(numBits),
    .ctrl(ctrl), .nEff(nEff), .busy(busy), .cmpStrobe(cmpStrobe)
  );

  rsd_seq_datapath #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .nEff(nEff),
    .cmpAbove(cmpAbove), .cmpBelow(cmpBelow),
    .resSel(resSel), .resUpdate(resUpdate), .result(result),
    .done(done), .err(err)
  );
endmodule

// File: rtl/rsd_sequencer_chk.sv
module rsd_sequencer_chk #(
  parameter int MAX_BITS = 15
) (
  input logic                clk,
  input logic                rstN,
  input logic                start,
  input logic                cmpAbove,
  input logic                cmpBelow,
  input logic                cmpStrobe,
  input logic                resUpdate,
  input logic [1:0]          resSel,
  input logic                busy,
  input logic                done,
  input logic [MAX_BITS-1:0] result,
  input logic                err
);
  AST_DECIDE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    resUpdate |-> $past(cmpStrobe)); // R2
  AST_STROBE_THEN_DECIDE: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |=> resUpdate); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!cmpStrobe && !resUpdate)); // R2
  AST_SEL_ABOVE: assert property (@(posedge clk) disable iff (!rstN)
    (resUpdate && cmpAbove && !cmpBelow) |-> resSel == 2'b10); // R3
  AST_SEL_BELOW: assert property (@(posedge clk) disable iff (!rstN)
    (resUpdate && cmpBelow && !cmpAbove) |-> resSel == 2'b01); // R3
  AST_SEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !resUpdate |-> resSel == 2'b00); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result)); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (err && !(start && !busy)) |=> err); // R7
  AST_ERR_ON_CONFLICT: assert property (@(posedge clk) disable iff (!rstN)
    (resUpdate && cmpAbove && cmpBelow) |=> err); // R7
endmodule

bind rsd_sequencer rsd_sequencer_chk #(.MAX_BITS(MAX_BITS)) i_chk (
  .clk(clk), .rstN(rstN), .start(start), .cmpAbove(cmpAbove),
  .cmpBelow(cmpBelow), .cmpStrobe(cmpStrobe), .resUpdate(resUpdate),
  .resSel(resSel), .busy(busy), .done(done), .result(result), .err(err)
);

// File: tb/test_rsd_sequencer.sv
module test_rsd_sequencer;
  localparam int  MAX_BITS = 15;
  localparam int  CNT_W    = $clog2(MAX_BITS + 1);
  localparam time CLK_P    = 10;
  localparam int  WDOG     = 20000;
  localparam real VREF     = 1.0;
  localparam real VTH      = 0.25;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] numBits = '0;
  logic cmpAbove = 1'b0, cmpBelow = 1'b0;
  logic cmpStrobe, resUpdate, busy, done, err;
  logic [1:0] resSel;
  logic [MAX_BITS-1:0] result;

  int checks = 0, errors = 0, cyc = 0;
  logic [MAX_BITS-1:0] heldResult = '0;

  always #(CLK_P/2) clk = ~clk;

  rsd_sequencer #(.MAX_BITS(MAX_BITS)) i_rsd_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .numBits(numBits),
    .cmpAbove(cmpAbove), .cmpBelow(cmpBelow), .cmpStrobe(cmpStrobe),
    .resUpdate(resUpdate), .resSel(resSel), .busy(busy), .done(done),
    .result(result), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // mode 0: analog model, 1: always above, 2: always below, 3: analog with both flags at digit conflictAt
  task automatic runConv(input real vin, input int reqN, input int mode,
                         input int conflictAt, input bit pokeStart);
    int n;
    longint acc, lim, expRes;
    real vx;
    bit expErr;
    n = (reqN < 2) ? 2 : ((reqN > MAX_BITS) ? MAX_BITS : reqN);
    acc = 0; vx = vin; expErr = 1'b0;
    @(negedge clk);
    start = 1'b1; numBits = CNT_W'(reqN);
    @(negedge clk);
    start = 1'b0;
    numBits = CNT_W'(3);                          // R4 change mid-run
    for (int i = 0; i < n; i++) begin
      // strobe cycle; junk flags to be ignored (R10)
      cmpAbove = 1'b1; cmpBelow = 1'b1;
      if (pokeStart && i == 1) start = 1'b1;      // R8
      #1;
      chk(cmpStrobe === 1'b1, "R2", "cmpStrobe in strobe cycle", cmpStrobe, 1);
      chk(resUpdate === 1'b0 && resSel === 2'b00, "R3", "quiet outside decision", resSel, 0);
      chk(busy === 1'b1, "R2", "busy during run", busy, 1);
      chk(result === heldResult, "R9", "result held during run", result, heldResult);
      if (i == 0) chk(err === 1'b0, "R7", "err cleared by start", err, 0);
      else chk(err === expErr, "R10", "err after junk flags", err, expErr);
      @(negedge clk);
      start = 1'b0;
      begin
        int d;
        bit a, b;
        a = (mode == 1) || ((mode == 0 || mode == 3) && vx > VTH);
        b = (mode == 2) || ((mode == 0 || mode == 3) && vx < -VTH);
        if (mode == 3 && i == conflictAt) begin a = 1'b1; b = 1'b1; expErr = 1'b1; end
        cmpAbove = a; cmpBelow = b;
        d = (a && !b) ? 1 : ((b && !a) ? -1 : 0);
        #1;
        chk(resUpdate === 1'b1, "R2", "resUpdate in decision cycle", resUpdate, 1);
        chk(resSel === ((d == 1) ? 2'b10 : (d == -1) ? 2'b01 : 2'b00), "R3",
            "resSel code", resSel, d);
        acc = 2 * acc + d;
        vx = 2.0 * vx - real'(d) * VREF;
      end
      @(negedge clk);
    end
    cmpAbove = 1'b0; cmpBelow = 1'b0;
    lim = (64'sd1 <<< (n - 1));
    expRes = (acc > lim - 1) ? lim - 1 : ((acc < -lim) ? -lim : acc);
    #1;
    chk(done === 1'b1, "R5", "done pulse at 2n", done, 1);
    chk(busy === 1'b0, "R5", "idle with done", busy, 0);
    chk(result === MAX_BITS'(expRes),
        (acc != expRes) ? "R6" : "R5", "result value", $signed(result), expRes);
    chk(err === expErr, "R7", "err at done", err, expErr);
    heldResult = MAX_BITS'(expRes);
    @(negedge clk);
    chk(done === 1'b0, "R5", "done one cycle", done, 0);
    chk(cmpStrobe === 1'b0 && busy === 1'b0, "R4", "no extra iteration", cmpStrobe, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WDOG);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && err === 1'b0, "R1", "reset flags", {busy, done, err}, 0);
    chk(cmpStrobe === 1'b0 && resUpdate === 1'b0 && resSel === 2'b00, "R1", "reset controls",
        {cmpStrobe, resUpdate, resSel}, 0);
    chk(result === '0, "R1", "reset result", result, 0);
    rstN = 1'b1;
    @(negedge clk);

    runConv(0.3, 13, 0, 0, 1'b0);
    runConv(-0.37, 14, 0, 0, 1'b1);      // R8 start while busy
    runConv(0.9, 8, 0, 0, 1'b0);
    runConv(0.0, 15, 1, 0, 1'b0);        // R6 upper clamp
    runConv(0.0, 5, 2, 0, 1'b0);         // R6 lower clamp
    runConv(0.12, 1, 0, 0, 1'b0);        // R4 clamp up to 2
    runConv(-0.2, 0, 0, 0, 1'b0);        // R4 clamp up to 2
    runConv(0.41, 6, 3, 3, 1'b0);        // R7 conflict

    // idle with junk flags: nothing changes (R10, R9, R7 sticky)
    cmpAbove = 1'b1; cmpBelow = 1'b1;
    repeat (5) @(negedge clk);
    chk(result === heldResult, "R9", "result held in idle", result, heldResult);
    chk(err === 1'b1, "R7", "err sticky in idle", err, 1);
    chk(cmpStrobe === 1'b0 && resUpdate === 1'b0, "R10", "idle flags ignored", resUpdate, 0);
    cmpAbove = 1'b0; cmpBelow = 1'b0;

    runConv(-0.05, 10, 0, 0, 1'b0);      // clears err
    runConv(0.49, 15, 0, 0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule